// File: doc/BRIEF.md
# Half-Step Clock Divider with Balanced Duty

This block derives a slower clock from a fast input clock that runs at twice a reference rate. The divisor, counted in reference periods, is picked from a set of eight values. Two of them are half-integers (1.5 and 2.5), and every choice yields an output that is high for exactly half of its period. The design works on a grid of half input periods. A counter on the rising edge sets the base waveform. A flop on the falling edge stretches the high phase by half an input cycle when the period in input cycles is odd. Every output rising edge falls on a rising edge of the input clock.

The divisor is captured only while reset is held. Once reset is released, a settling counter runs for a fixed number of input cycles, then raises the locked flag, and the divided clock starts on the next rising edge. The divided output stays low for as long as locked is low. Changing the select while the block runs has no effect until the next reset.

Top module: `halfstep_clk_div`

## Requirements
- R1: The select code picks the output period in input-clock cycles: 0→3, 1→4, 2→5, 3→6, 4→8, 5→10, 6→16, 7→32. This equals twice the divisor 1.5, 2, 2.5, 3, 4, 5, 8, 16 in reference periods.
- R2: For every select code the divided output is high for exactly half of its period, measured in half input cycles.
- R3: Each rising edge of the divided output coincides with a rising edge of the input clock. The first one comes on the input rising edge after locked rises.
- R4: With reset released before input rising edge 1, locked is low through edge LOCK_CYCLES-1 and high from edge LOCK_CYCLES on.
- R5: While locked is low, the divided output is low.
- R6: A change of the select input while reset is low has no effect on the running output. The value present at the last rising edge with reset high is used.
- R7: Asserting reset clears locked at the next input rising edge, and the divided output is low by the following falling edge.
- R8: For odd periods (codes 0 and 2), the output falls on a falling edge of the input clock. For even periods it falls on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Input clock at twice the reference rate |
| rst_i | input | 1 | Synchronous active-high reset; also loads the select |
| sel_i | input | 3 | Divisor select code |
| clk_div_o | output | 1 | Divided clock with balanced duty |
| locked_o | output | 1 | High once settling has finished |

## Verification
The bench samples the output in every half input cycle and compares it with a waveform built from the period table. If the falling-edge stretch is wrong, codes 0 and 2 come out one half cycle short or long. If the counter wraps at the wrong point, the period drifts and the rise slots stop matching. The lock edge is checked cycle by cycle, so a settling count that is off by one is caught, and so is an output that leaks a pulse before locked. Some runs poke the select mid-run, and some runs assert reset mid-period while the falling-edge flop may still be high. These catch a select that is sampled outside reset and an output that does not clear.

// File: rtl/hscd_pkg.sv
package hscd_pkg;
  localparam int unsigned PER_W = 6;
  typedef logic [2:0] div_sel_t;

  // output period in input-clock cycles (twice the divisor)
  function automatic logic [PER_W-1:0] period_of(input div_sel_t s);
    case (s)
      3'd0:    return 6'd3;
      3'd1:    return 6'd4;
      3'd2:    return 6'd5;
      3'd3:    return 6'd6;
      3'd4:    return 6'd8;
      3'd5:    return 6'd10;
      3'd6:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  // whole input cycles of the high phase driven by the rising-edge path
  function automatic logic [PER_W-1:0] rise_high_of(input logic [PER_W-1:0] p);
    return p >> 1;
  endfunction

  function automatic logic needs_half_of(input logic [PER_W-1:0] p);
    return p[0];
  endfunction
endpackage

// File: rtl/hscd_cfg.sv
module hscd_cfg
  import hscd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  div_sel_t         sel_i,
  output logic [PER_W-1:0] period_o,
  output logic [PER_W-1:0] hi_len_o,
  output logic             half_o
);
  div_sel_t sel_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sel_q <= sel_i;
  end

  assign period_o = period_of(sel_q);
  assign hi_len_o = rise_high_of(period_o);
  assign half_o   = needs_half_of(period_o);

  // R6
  sel_frozen_chk: assert property (@(posedge clk_i) !rst_i |=> $stable(sel_q));
endmodule

// File: rtl/hscd_lock.sv
module hscd_lock #(
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic locked_o
);
  localparam int unsigned LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] LAST = LW'(LOCK_CYCLES - 1);

  logic [LW-1:0] settle_q;
  logic          locked_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      settle_q <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (settle_q == LAST) locked_q <= 1'b1;
      else                  settle_q <= settle_q + 1'b1;
    end
  end

  assign locked_o = locked_q;

  // R7
  lock_clear_chk: assert property (@(posedge clk_i) rst_i |=> !locked_o);
  // R4
  lock_after_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_o |-> settle_q == LAST);
endmodule

// File: rtl/hscd_phase.sv
module hscd_phase
  import hscd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] hi_len_i,
  input  logic             half_i,
  output logic             clk_div_o
);
  logic [PER_W-1:0] cnt_q;
  logic             rise_q;
  logic             fall_q;
  logic             wrap;

  assign wrap = (cnt_q == period_i - 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= (cnt_q < hi_len_i);
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // half-cycle stretch for odd periods
  always_ff @(negedge clk_i) begin
    if (rst_i) fall_q <= 1'b0;
    else       fall_q <= rise_q & half_i;
  end

  assign clk_div_o = rise_q | fall_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < period_i);
  // R5
  idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> !rise_q);
  // R8
  stretch_odd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_q |-> half_i);
endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div #(
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic       clk2x_i,
  input  logic       rst_i,
  input  logic [2:0] sel_i,
  output logic       clk_div_o,
  output logic       locked_o
);
  import hscd_pkg::*;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] hi_len;
  logic             half;
  logic             locked;

  hscd_cfg u_cfg (
    .clk_i   (clk2x_i),
    .rst_i   (rst_i),
    .sel_i   (sel_i),
    .period_o(period),
    .hi_len_o(hi_len),
    .half_o  (half)
  );

  hscd_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i   (clk2x_i),
    .rst_i   (rst_i),
    .locked_o(locked)
  );

  hscd_phase u_phase (
    .clk_i    (clk2x_i),
    .rst_i    (rst_i),
    .run_i    (locked),
    .period_i (period),
    .hi_len_i (hi_len),
    .half_i   (half),
    .clk_div_o(clk_div_o)
  );

  assign locked_o = locked;
endmodule

// File: tb/tb_halfstep_clk_div.sv
`timescale 1ns/1ps
module tb_halfstep_clk_div;
  localparam int LOCK = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       dout;
  logic       lck;
  int checks = 0;
  int fails  = 0;

  halfstep_clk_div #(.LOCK_CYCLES(LOCK)) dut (
    .clk2x_i(clk), .rst_i(rst), .sel_i(sel), .clk_div_o(dout), .locked_o(lck)
  );

  always #2.5 clk = ~clk;

  // R1: twice the divisor, in input cycles
  function automatic int per_cycles(input logic [2:0] s);
    int twice [8] = '{3, 4, 5, 6, 8, 10, 16, 32};
    return twice[s];
  endfunction

  // expected output in half-slot `half` after input rising edge k
  function automatic bit exp_out(input int k, input int half, input int m);
    int h;
    if (k < LOCK + 1) return 1'b0;
    h = 2 * (k - LOCK - 1) + half;
    return (h % (2 * m)) < m;
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string out_tag(input int k, input int half, input int m, input bit poked);
    int h;
    if (k < LOCK + 1) return "R5";
    if (poked) return "R6";
    h = 2 * (k - LOCK - 1) + half;
    if (h % (2 * m) == 0) return "R3";
    if (m % 2 == 1) return "R8";
    return "R2";
  endfunction

  task automatic run_case(input logic [2:0] s, input int extra, input bit poke, input bit mid_reset);
    int m = per_cycles(s);
    int total = LOCK + 1 + extra;
    bit poked = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    sel = ~s;
    repeat (2) @(negedge clk);
    sel = s;
    @(negedge clk);
    #1.25;
    chk(dout, 1'b0, "R7 reset out");
    chk(lck, 1'b0, "R7 reset lock");
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= total; k++) begin
      @(posedge clk);
      #1.25;
      chk(lck, k >= LOCK, "R4");
      chk(dout, exp_out(k, 0, m), out_tag(k, 0, m, poked));
      @(negedge clk);
      #1.25;
      chk(dout, exp_out(k, 1, m), out_tag(k, 1, m, poked));
      if (poke && k == LOCK + 3) begin
        sel = s + 3'($urandom_range(1, 7));
        poked = 1'b1;
      end
    end
    if (mid_reset) begin
      rst = 1'b1;
      @(posedge clk);
      #1.25;
      chk(lck, 1'b0, "R7 mid lock");
      @(negedge clk);
      #1.25;
      chk(dout, 1'b0, "R7 mid out");
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // directed: every code, two full periods each
    for (int s = 0; s < 8; s++) run_case(3'(s), 2 * per_cycles(3'(s)), 1'b0, 1'b0);
    // half-integer codes with a select poke and a mid-period reset
    run_case(3'd0, 7, 1'b1, 1'b1);
    run_case(3'd2, 12, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 12; i++) begin
      logic [2:0] rs = 3'($urandom_range(0, 7));
      run_case(rs, $urandom_range(1, 3 * per_cycles(rs)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule